// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

This block takes a single command that moves a run of consecutive floating-point registers to or from memory and splits it into a stream of word-sized micro-ops. The command gives an integer base register, the first floating-point register, a register count, and four mode bits: single or double precision, address direction, load or store, and base writeback. Each double-precision register is sent as two 32-bit halves at neighbouring addresses. The optional writeback appears as one final micro-op that moves the base register past the block.

Commands enter on a valid/ready port that accepts only while the sequencer is idle. Micro-ops leave on a valid/ready stream. While `uop_valid` is high and `uop_ready` is low, every micro-op field is held unchanged. There are no gaps inside a sequence, and the next command is accepted in the cycle after the last micro-op is taken. Byte offsets are two's-complement values relative to the base register. The block moves no data itself.

Top module: `fpx_xfer_seq`

## Requirements
- R1: A command with count 0 and writeback off is accepted and produces no micro-op. `cmd_ready` stays high and `uop_valid` stays low.
- R2: A command produces exactly count×(1 if single, else 2) + (1 if writeback) micro-ops. After the last one is taken, `uop_valid` is low in the next cycle.
- R3: Single precision gives one transfer per register with `uop_half`=0. The offset of register k is +4k when incrementing and −4k when decrementing.
- R4: Double precision gives two transfers per register. The bottom half (`uop_half`=0) comes first, at ±8k. The top half (`uop_half`=1) follows at that offset +4 when incrementing, or −4 when decrementing.
- R5: `uop_reg` starts at the command's first register and increases by one after every transfer micro-op, wrapping modulo 2^REG_W.
- R6: With writeback on, the last micro-op has opcode 2 (add) when incrementing or 3 (subtract) when decrementing. Its `uop_ofs` is 4×(number of transfer words), its `uop_half` is 0, and `uop_base` carries the command's base register.
- R7: Transfer micro-ops use opcode 0 for a load and 1 for a store. `uop_up` gives the command's direction on every micro-op.
- R8: Only the first micro-op of a sequence has `uop_first`=1, and only the last has `uop_last`=1. `uop_dcommit` is 1 on every micro-op except the last.
- R9: While `uop_valid`=1 and `uop_ready`=0, all micro-op fields hold. `cmd_ready` is low while a sequence is in flight, and a command offered then is ignored.
- R10: After reset, `uop_valid`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_base | input | BASE_W | Integer base register index |
| cmd_freg | input | REG_W | First floating-point register |
| cmd_count | input | CNT_W | Number of registers |
| cmd_single | input | 1 | 1 = single precision, 0 = double |
| cmd_up | input | 1 | 1 = incrementing addresses |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Write the base register back at the end |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 2 | 0 load, 1 store, 2 base add, 3 base subtract |
| uop_reg | output | REG_W | Floating-point register of a transfer |
| uop_base | output | BASE_W | Base register index |
| uop_half | output | 1 | 0 bottom or single word, 1 top half |
| uop_ofs | output | CNT_W+5 | Signed byte offset, or writeback amount |
| uop_up | output | 1 | Direction of the command |
| uop_first | output | 1 | First micro-op of the sequence |
| uop_last | output | 1 | Last micro-op of the sequence |
| uop_dcommit | output | 1 | Commit is held back until the sequence ends |

## Verification
Two things can fall in the same cycle: the final micro-op leaving the stream, and a new command arriving. The bench offers junk commands during every sequence. It stops offering them only in the cycle of the last micro-op, and it stalls the stream at random. A command that slipped in would corrupt the register, offset or count of the stream being compared. A gap or a late return of `cmd_ready` after the last handshake is judged by checking, one clock later, that the block is idle and the stream has ended.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    UOP_LOAD     = 2'd0,
    UOP_STORE    = 2'd1,
    UOP_BASE_ADD = 2'd2,
    UOP_BASE_SUB = 2'd3
  } uop_op_e;
endpackage

// File: rtl/fpx_plan.sv
// Sizes a command: how many micro-ops it needs and how far the base moves.
module fpx_plan #(
  parameter int CNT_W = 5,
  parameter int TOT_W = CNT_W + 1,
  parameter int OFS_W = CNT_W + 5
) (
  input  logic [CNT_W-1:0] count,
  input  logic             single,
  input  logic             wb,
  output logic [TOT_W-1:0] total,
  output logic [OFS_W-1:0] wb_imm
);
  logic [TOT_W-1:0] words;
  always_comb begin
    words  = single ? TOT_W'(count) : (TOT_W'(count) << 1);
    total  = words + TOT_W'(wb);
    wb_imm = OFS_W'(words) << 2;
  end
endmodule

// File: rtl/fpx_offset_gen.sv
// Offset of the current word and of the next register slot.
module fpx_offset_gen #(
  parameter int OFS_W = 10
) (
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic             single,
  input  logic             up,
  input  logic             half,
  output logic [OFS_W-1:0] emit_ofs,
  output logic [OFS_W-1:0] next_ofs
);
  localparam logic [OFS_W-1:0] WORD_BYTES = OFS_W'(4);
  logic [OFS_W-1:0] slot_bytes;
  always_comb begin
    slot_bytes = single ? WORD_BYTES : (WORD_BYTES << 1);
    if (half) emit_ofs = up ? reg_ofs + WORD_BYTES : reg_ofs - WORD_BYTES;
    else      emit_ofs = reg_ofs;
    next_ofs = up ? reg_ofs + slot_bytes : reg_ofs - slot_bytes;
  end
endmodule

// File: rtl/fpx_xfer_seq.sv
module fpx_xfer_seq #(
  parameter int REG_W  = 5,
  parameter int CNT_W  = 5,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BASE_W-1:0] cmd_base,
  input  logic [REG_W-1:0]  cmd_freg,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_single,
  input  logic              cmd_up,
  input  logic              cmd_load,
  input  logic              cmd_wb,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [1:0]        uop_op,
  output logic [REG_W-1:0]  uop_reg,
  output logic [BASE_W-1:0] uop_base,
  output logic              uop_half,
  output logic [CNT_W+4:0]  uop_ofs,
  output logic              uop_up,
  output logic              uop_first,
  output logic              uop_last,
  output logic              uop_dcommit
);
  import fpx_pkg::*;
  localparam int TOT_W = CNT_W + 1;
  localparam int OFS_W = CNT_W + 5;

  logic              busy_q, single_q, up_q, load_q, wb_q, half_q, first_q;
  logic [BASE_W-1:0] base_q;
  logic [TOT_W-1:0]  left_q;
  logic [REG_W-1:0]  reg_q;
  logic [OFS_W-1:0]  rofs_q, imm_q;

  logic [TOT_W-1:0]  plan_total;
  logic [OFS_W-1:0]  plan_imm, emit_ofs, next_ofs;
  logic              accept, fire, on_last, is_wb;
  uop_op_e           op_sel;

  fpx_plan #(.CNT_W(CNT_W), .TOT_W(TOT_W), .OFS_W(OFS_W)) u_plan (
    .count (cmd_count), .single(cmd_single), .wb(cmd_wb),
    .total (plan_total), .wb_imm(plan_imm)
  );

  fpx_offset_gen #(.OFS_W(OFS_W)) u_ofs (
    .reg_ofs(rofs_q), .single(single_q), .up(up_q), .half(half_q),
    .emit_ofs(emit_ofs), .next_ofs(next_ofs)
  );

  always_comb begin
    accept  = cmd_valid && !busy_q;
    fire    = busy_q && uop_ready;
    on_last = (left_q == TOT_W'(1));
    is_wb   = wb_q && on_last;
    if (is_wb) op_sel = up_q ? UOP_BASE_ADD : UOP_BASE_SUB;
    else       op_sel = load_q ? UOP_LOAD : UOP_STORE;
  end

  assign cmd_ready   = !busy_q;
  assign uop_valid   = busy_q;
  assign uop_op      = op_sel;
  assign uop_reg     = reg_q;
  assign uop_base    = base_q;
  assign uop_half    = half_q && !is_wb;
  assign uop_ofs     = is_wb ? imm_q : emit_ofs;
  assign uop_up      = up_q;
  assign uop_first   = first_q;
  assign uop_last    = on_last;
  assign uop_dcommit = !on_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; single_q <= 1'b0; up_q <= 1'b0; load_q <= 1'b0;
      wb_q <= 1'b0; half_q <= 1'b0; first_q <= 1'b0;
      base_q <= '0; left_q <= '0; reg_q <= '0; rofs_q <= '0; imm_q <= '0;
    end else if (accept) begin
      busy_q   <= (plan_total != '0);
      single_q <= cmd_single;
      up_q     <= cmd_up;
      load_q   <= cmd_load;
      wb_q     <= cmd_wb;
      base_q   <= cmd_base;
      left_q   <= plan_total;
      reg_q    <= cmd_freg;
      rofs_q   <= '0;
      imm_q    <= plan_imm;
      half_q   <= 1'b0;
      first_q  <= 1'b1;
    end else if (fire) begin
      left_q  <= left_q - TOT_W'(1);
      first_q <= 1'b0;
      if (on_last) busy_q <= 1'b0;
      if (!is_wb) begin
        reg_q <= reg_q + REG_W'(1);
        if (single_q || half_q) begin
          half_q <= 1'b0;
          rofs_q <= next_ofs;
        end else begin
          half_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fpx_seq_chk.sv
module fpx_seq_chk #(
  parameter int REG_W  = 5,
  parameter int CNT_W  = 5,
  parameter int BASE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [1:0]       uop_op,
  input logic [REG_W-1:0] uop_reg,
  input logic             uop_half,
  input logic [CNT_W+4:0] uop_ofs,
  input logic             uop_up,
  input logic             uop_first,
  input logic             uop_last
);
  localparam int OFS_W = CNT_W + 5;
  logic fire;
  logic [OFS_W-1:0] hstep;
  assign fire  = uop_valid && uop_ready;
  assign hstep = uop_up ? OFS_W'(4) : OFS_W'(-4);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_reg)
      && $stable(uop_ofs) && $stable(uop_half) && $stable(uop_last));

  assert_cmd_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !cmd_ready);

  assert_wb_is_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_op[1] |-> uop_last);

  assert_top_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !uop_op[1] && !uop_half && !uop_last |=>
      (!(uop_valid && uop_half) ||
       (uop_reg == $past(uop_reg) + REG_W'(1) && uop_ofs == $past(uop_ofs) + $past(hstep))));

  assert_first_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !uop_last |=> uop_valid && !uop_first);

  assert_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && uop_last |=> !uop_valid && cmd_ready);
endmodule

bind fpx_xfer_seq fpx_seq_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .uop_valid(uop_valid),
  .uop_ready(uop_ready), .uop_op(uop_op), .uop_reg(uop_reg), .uop_half(uop_half),
  .uop_ofs(uop_ofs), .uop_up(uop_up), .uop_first(uop_first), .uop_last(uop_last)
);

// File: tb/fpx_xfer_seq_bench.sv
module fpx_xfer_seq_bench;
  localparam int REG_W = 5, CNT_W = 5, BASE_W = 4;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [BASE_W-1:0] cmd_base = 0;
  logic [REG_W-1:0] cmd_freg = 0;
  logic [CNT_W-1:0] cmd_count = 0;
  logic cmd_single = 0, cmd_up = 0, cmd_load = 0, cmd_wb = 0;
  logic uop_valid, uop_ready = 0;
  logic [1:0] uop_op;
  logic [REG_W-1:0] uop_reg;
  logic [BASE_W-1:0] uop_base;
  logic uop_half, uop_up, uop_first, uop_last, uop_dcommit;
  logic [CNT_W+4:0] uop_ofs;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  fpx_xfer_seq #(.REG_W(REG_W), .CNT_W(CNT_W), .BASE_W(BASE_W)) u_fpx_xfer_seq (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(int freg, int cnt, bit sgl, bit up, bit ld, bit wb, int base);
    int wpr = sgl ? 1 : 2;
    int total = cnt * wpr + (wb ? 1 : 0);
    int idx = 0;
    int guard = 0;
    @(negedge clk);
    cmd_freg = REG_W'(freg); cmd_count = CNT_W'(cnt); cmd_single = sgl;
    cmd_up = up; cmd_load = ld; cmd_wb = wb; cmd_base = BASE_W'(base);
    cmd_valid = 1; uop_ready = 0;
    #1 chk(cmd_ready == 1, "R9 idle ready", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 0;
    if (total == 0) begin
      #1;
      chk(uop_valid == 0, "R1 no uop", int'(uop_valid), 0);
      chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
      return;
    end
    while (idx < total && guard < 400) begin
      guard++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      uop_ready = lfsr[0] | lfsr[1];
      // junk command offered while busy, withdrawn for the final micro-op
      cmd_valid = (idx < total - 1);
      cmd_freg = REG_W'(freg + 9); cmd_count = CNT_W'(1); cmd_wb = !wb;
      cmd_single = !sgl; cmd_up = !up; cmd_load = !ld; cmd_base = BASE_W'(base + 3);
      #1;
      chk(uop_valid == 1, "R2 no gap", int'(uop_valid), 1);
      chk(cmd_ready == 0, "R9 busy", int'(cmd_ready), 0);
      if (uop_ready) begin
        bit is_wb = wb && (idx == total - 1);
        int s = up ? 1 : -1;
        int r = idx / wpr;
        int h = sgl ? 0 : idx % 2;
        int e_op, e_ofs, e_half;
        if (is_wb) begin
          e_op = up ? 2 : 3; e_ofs = cnt * wpr * 4; e_half = 0;
          chk(uop_op == 2'(e_op), "R6 op", int'(uop_op), e_op);
          chk(int'($signed(uop_ofs)) == e_ofs, "R6 imm", int'($signed(uop_ofs)), e_ofs);
          chk(uop_base == BASE_W'(base), "R6 base", int'(uop_base), base);
          chk(uop_half == 0, "R6 half", int'(uop_half), 0);
        end else begin
          e_op = ld ? 0 : 1;
          e_ofs = s * r * wpr * 4 + (h != 0 ? s * 4 : 0);
          e_half = h;
          chk(uop_op == 2'(e_op), "R7 op", int'(uop_op), e_op);
          chk(int'($signed(uop_ofs)) == e_ofs, sgl ? "R3 ofs" : "R4 ofs",
              int'($signed(uop_ofs)), e_ofs);
          chk(int'(uop_half) == e_half, sgl ? "R3 half" : "R4 half", int'(uop_half), e_half);
          chk(int'(uop_reg) == (freg + idx) % 32, "R5 reg", int'(uop_reg), (freg + idx) % 32);
        end
        chk(uop_up == up, "R7 dir", int'(uop_up), int'(up));
        chk(uop_first == (idx == 0), "R8 first", int'(uop_first), int'(idx == 0));
        chk(uop_last == (idx == total - 1), "R8 last", int'(uop_last), int'(idx == total - 1));
        chk(uop_dcommit == (idx != total - 1), "R8 dcommit", int'(uop_dcommit),
            int'(idx != total - 1));
        idx++;
      end
      @(negedge clk);
    end
    cmd_valid = 0; uop_ready = 0;
    #1;
    chk(idx == total, "R2 guard", idx, total);
    chk(uop_valid == 0, "R2 count end", int'(uop_valid), 0);
    chk(cmd_ready == 1, "R8 idle after last", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(uop_valid == 0, "R10 valid", int'(uop_valid), 0);
    chk(cmd_ready == 1, "R10 ready", int'(cmd_ready), 1);
    rst_n = 1;
    for (int c = 0; c <= 4; c++)
      for (int m = 0; m < 16; m++)
        run_cmd((c * 7 + m) % 32, c, m[0], m[1], m[2], m[3], m);
    run_cmd(30, 3, 0, 1, 1, 1, 5);   // R5 wrap, double
    run_cmd(31, 2, 1, 0, 0, 0, 2);   // R5 wrap, single
    run_cmd(0, 31, 0, 0, 1, 1, 9);   // largest count, decrementing
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule